// File: doc/BRIEF.md
# Serial Memory Slave with Status and Protection

This block is a serial-peripheral slave that fronts a 2048-byte on-chip memory and a small status register. After the select line goes low, the host shifts in an 8-bit instruction. Memory instructions then take a two-byte address, and the block streams data bytes in or out. The address steps after every byte, so one transfer can cover any number of consecutive locations. A local system clock samples all serial pins, so the block is fully synchronous and has no clock taken from the pins.

The status register holds a write-enable latch, two block-protect bits and one spare enable bit. These decide whether a memory write or a status write may land. The hold input lets a host pause a transfer in the middle of a byte and resume it later with nothing lost. The write-protect input locks the status register. The serial output comes with a separate enable, so a pad can tri-state it.

Top module: `serial_mem_slave`

## Requirements
- R1: While `cs_n` is high, and the block is not held, the serial clock and data pins have no effect, `so_oe` is low, and the next select starts a fresh instruction. A transfer left unfinished when `cs_n` rises is dropped, and a partly shifted data byte is never written.
- R2: `si` is taken on rising `sck` edges and `so` changes on falling edges. Every byte, in either direction, travels most significant bit first.
- R3: Opcode 0x06 sets the write-enable latch (WEL) and opcode 0x04 clears it.
- R4: Opcode 0x05 returns the status byte, repeated for as long as clocks continue. The byte holds WEL at bit 1, block-protect at bits 3:2, the enable bit at bit 7, and zeros in every other bit.
- R5: Opcode 0x01 takes one byte and loads bits 7 and 3:2 only if WEL is 1 and `wp_n` is high. When `wp_n` is low, those bits keep their values.
- R6: Opcode 0x03, followed by a 16-bit address sent high byte first, returns bytes starting at the low 11 address bits. The upper 5 bits are ignored. The address steps by one after each byte.
- R7: Opcode 0x02, followed by an address, stores each data byte as soon as its eighth bit arrives, but only while WEL is 1. With WEL at 0 the byte is discarded.
- R8: The address counter wraps from 0x7FF to 0x000.
- R9: A memory write is discarded when block-protect is 01 and the address is 0x600 to 0x7FF, when it is 10 and the address is 0x400 to 0x7FF, or when it is 11 (any address).
- R10: When `cs_n` rises after at least one complete data byte of a memory write, or a complete status byte, WEL is cleared. This holds even if protection discarded the byte.
- R11: While `hold_n` is low (it changes only while `sck` is low), clock and select edges are ignored and `so_oe` is low. On release, the transfer resumes from the exact bit where it stopped.
- R12: An unrecognised opcode makes the block ignore everything until `cs_n` rises. `so_oe` stays low in that time.
- R13: After reset, the status byte reads 0x00 and `so_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every serial pin |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause request |
| wp_n | input | 1 | Active-low status-register write lock |
| so | output | 1 | Serial data out (low while not enabled) |
| so_oe | output | 1 | Output enable for `so` |

## Verification
Some rules are checked on every cycle by the assertions. The output stays off and the state returns to the instruction phase once select is high. State and address stay frozen and the output is released while held. Status bits never move while write-protect is low. The address advances by exactly one after each stored byte. `so` never changes on the cycle after a rising clock edge. A protected write never reaches the array with all blocks locked. Other behaviour only the directed scenarios can show: that stored data actually reads back, that the upper address bits are ignored, that wrap-around, discarded writes and latch clearing happen, and that a held read resumes with an intact byte.

// File: rtl/sms_pkg.sv
package sms_pkg;
   localparam int BYTE_W = 8;

   localparam logic [7:0] OP_WREN = 8'h06;
   localparam logic [7:0] OP_WRDI = 8'h04;
   localparam logic [7:0] OP_RDSR = 8'h05;
   localparam logic [7:0] OP_WRSR = 8'h01;
   localparam logic [7:0] OP_READ = 8'h03;
   localparam logic [7:0] OP_WRIT = 8'h02;

   typedef enum logic [2:0] {
      ST_CMD    = 3'd0,
      ST_ADDR   = 3'd1,
      ST_RDMEM  = 3'd2,
      ST_WRMEM  = 3'd3,
      ST_RDSR   = 3'd4,
      ST_WRSR   = 3'd5,
      ST_IGNORE = 3'd6
   } state_e;
endpackage

// File: rtl/sms_sync.sv
module sms_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 0) begin : g_bad
         $error("sms_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] ff [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) ff[i] <= RST_VAL;
            end else begin
               ff[0] <= d;
               for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
            end
         end
         assign q = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sms_protect.sv
module sms_protect (
   input  logic [1:0] top_bits,
   input  logic [1:0] bp,
   output logic       hit
);
   always_comb begin
      unique case (bp)
         2'b00:   hit = 1'b0;
         2'b01:   hit = (top_bits == 2'b11);
         2'b10:   hit = top_bits[1];
         default: hit = 1'b1;
      endcase
   end
endmodule

// File: rtl/sms_array.sv
module sms_array #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
   parameter int ADDR_W      = 11,
   parameter int ADDR_BYTES  = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic si,
   input  logic hold_n,
   input  logic wp_n,
   output logic so,
   output logic so_oe
);
   import sms_pkg::*;

   localparam int FIELD_W = BYTE_W * ADDR_BYTES;
   localparam int CNT_W   = $clog2(FIELD_W);
   localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] LAST_ABIT = CNT_W'(FIELD_W - 1);

   generate
      if (ADDR_W < 2 || ADDR_W > FIELD_W) begin : g_bad_addr
         $error("serial_mem_slave: ADDR_W must lie in 2..8*ADDR_BYTES");
      end
      if (ADDR_BYTES < 1) begin : g_bad_bytes
         $error("serial_mem_slave: ADDR_BYTES must be at least 1");
      end
   endgenerate

   // ---------------- pin sampling ----------------
   logic [4:0] pins_s;
   logic       cs_s, wp_s, hold_s, si_s, sck_s;

   sms_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11100)) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({cs_n, wp_n, hold_n, si, sck}),
      .q    (pins_s)
   );
   assign {cs_s, wp_s, hold_s, si_s, sck_s} = pins_s;

   // ---------------- hold and edge detection ----------------
   logic held, sck_prev, active, sck_rise, sck_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held     <= 1'b0;
         sck_prev <= 1'b0;
      end else begin
         sck_prev <= sck_s;
         if (!sck_s) held <= !hold_s;
      end
   end

   assign active   = !cs_s && !held;
   assign sck_rise = active &&  sck_s && !sck_prev;
   assign sck_fall = active && !sck_s &&  sck_prev;

   // ---------------- transfer state ----------------
   state_e              st_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [FIELD_W-1:0]  sh_q;
   logic [FIELD_W-1:0]  shift_in;
   logic [BYTE_W-1:0]   byte_in;
   logic [ADDR_W-1:0]   addr_q, addr_in, addr_nx, rd_addr;
   logic [BYTE_W-1:0]   ob_q, rd_data;
   logic                is_rd_q, wel_q, wpen_q, wr_done_q;
   logic [1:0]          bp_q;
   logic [BYTE_W-1:0]   status;
   logic                prot_hit, mem_we, byte_end, sr_ok;

   assign shift_in = {sh_q[FIELD_W-2:0], si_s};
   assign byte_in  = shift_in[BYTE_W-1:0];
   assign addr_in  = shift_in[ADDR_W-1:0];
   assign addr_nx  = addr_q + 1'b1;
   assign rd_addr  = (st_q == ST_ADDR) ? addr_in : addr_nx;
   assign status   = {wpen_q, 3'b000, bp_q, wel_q, 1'b0};
   assign byte_end = (cnt_q == LAST_BIT);
   assign sr_ok    = wel_q && wp_s;

   sms_protect prot_i (
      .top_bits(addr_q[ADDR_W-1 -: 2]),
      .bp      (bp_q),
      .hit     (prot_hit)
   );

   assign mem_we = sck_rise && (st_q == ST_WRMEM) && byte_end && wel_q && !prot_hit;

   sms_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) array_i (
      .clk  (clk),
      .we   (mem_we),
      .waddr(addr_q),
      .wdata(byte_in),
      .raddr(rd_addr),
      .rdata(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_CMD;
         cnt_q     <= '0;
         sh_q      <= '0;
         addr_q    <= '0;
         ob_q      <= '0;
         is_rd_q   <= 1'b0;
         wel_q     <= 1'b0;
         wpen_q    <= 1'b0;
         bp_q      <= 2'b00;
         wr_done_q <= 1'b0;
      end else if (cs_s && !held) begin
         st_q      <= ST_CMD;
         cnt_q     <= '0;
         wr_done_q <= 1'b0;
         if (wr_done_q) wel_q <= 1'b0;
      end else if (sck_rise) begin
         sh_q  <= shift_in;
         cnt_q <= cnt_q + 1'b1;
         unique case (st_q)
            ST_CMD: if (byte_end) begin
               cnt_q <= '0;
               unique case (byte_in)
                  OP_WREN: begin wel_q <= 1'b1; st_q <= ST_IGNORE; end
                  OP_WRDI: begin wel_q <= 1'b0; st_q <= ST_IGNORE; end
                  OP_RDSR: begin ob_q <= status; st_q <= ST_RDSR; end
                  OP_WRSR: st_q <= ST_WRSR;
                  OP_READ: begin is_rd_q <= 1'b1; st_q <= ST_ADDR; end
                  OP_WRIT: begin is_rd_q <= 1'b0; st_q <= ST_ADDR; end
                  default: st_q <= ST_IGNORE;
               endcase
            end
            ST_ADDR: if (cnt_q == LAST_ABIT) begin
               cnt_q  <= '0;
               addr_q <= addr_in;
               if (is_rd_q) begin
                  ob_q <= rd_data;
                  st_q <= ST_RDMEM;
               end else begin
                  st_q <= ST_WRMEM;
               end
            end
            ST_RDMEM: if (byte_end) begin
               cnt_q  <= '0;
               addr_q <= addr_nx;
               ob_q   <= rd_data;
            end
            ST_WRMEM: if (byte_end) begin
               cnt_q     <= '0;
               addr_q    <= addr_nx;
               wr_done_q <= 1'b1;
            end
            ST_RDSR: if (byte_end) begin
               cnt_q <= '0;
               ob_q  <= status;
            end
            ST_WRSR: if (byte_end) begin
               cnt_q     <= '0;
               wr_done_q <= 1'b1;
               st_q      <= ST_IGNORE;
               if (sr_ok) begin
                  wpen_q <= byte_in[7];
                  bp_q   <= byte_in[3:2];
               end
            end
            default: cnt_q <= '0;
         endcase
      end
   end

   // ---------------- output side ----------------
   logic so_q, so_oe_q, rd_phase;

   assign rd_phase = (st_q == ST_RDMEM) || (st_q == ST_RDSR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         so_q    <= 1'b0;
         so_oe_q <= 1'b0;
      end else begin
         so_oe_q <= active && rd_phase;
         if (cs_s && !held)              so_q <= 1'b0;
         else if (sck_fall && rd_phase)  so_q <= ob_q[~cnt_q[2:0]];
      end
   end

   assign so    = so_q & so_oe_q;
   assign so_oe = so_oe_q;
endmodule

// File: rtl/sms_checker.sv
module sms_checker #(
   parameter int ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_s,
   input logic              held,
   input logic              wp_s,
   input logic              sck_rise,
   input logic              mem_we,
   input logic              so_oe,
   input logic              so_q,
   input sms_pkg::state_e   st_q,
   input logic [ADDR_W-1:0] addr_q,
   input logic [1:0]        bp_q,
   input logic              wpen_q
);
   import sms_pkg::*;

   // R1
   cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s && !held) |=> (!so_oe && st_q == ST_CMD));

   // R11
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      held |=> ($stable(st_q) && $stable(addr_q)));

   // R11
   hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      held |=> !so_oe);

   // R5
   wp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_s |=> ($stable(bp_q) && $stable(wpen_q)));

   // R8
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (addr_q == $past(addr_q) + 1'b1));

   // R9
   full_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (bp_q != 2'b11));

   // R2
   so_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sck_rise |=> $stable(so_q));
endmodule

bind serial_mem_slave sms_checker #(.ADDR_W(ADDR_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_s    (cs_s),
   .held    (held),
   .wp_s    (wp_s),
   .sck_rise(sck_rise),
   .mem_we  (mem_we),
   .so_oe   (so_oe),
   .so_q    (so_q),
   .st_q    (st_q),
   .addr_q  (addr_q),
   .bp_q    (bp_q),
   .wpen_q  (wpen_q)
);

// File: tb/serial_mem_slave_tb.sv
module serial_mem_slave_tb_top;
   localparam int H = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
   logic so, so_oe;
   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   serial_mem_slave dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_xfer(input logic b, output logic r);
      si = b;
      wait_n(H);
      r = so;
      sck = 1'b1;
      wait_n(H);
      sck = 1'b0;
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         logic r;
         bit_xfer(tx[i], r);
         rx[i] = r;
      end
   endtask

   task automatic send(input logic [7:0] tx);
      logic [7:0] d;
      xfer(tx, d);
   endtask

   task automatic sel();
      cs_n = 1'b0;
      wait_n(H);
   endtask

   task automatic desel();
      wait_n(H);
      cs_n = 1'b1;
      wait_n(3 * H);
   endtask

   task automatic cmd1(input logic [7:0] op);
      sel(); send(op); desel();
   endtask

   task automatic rdsr(output logic [7:0] s);
      sel(); send(8'h05); xfer(8'h00, s); desel();
   endtask

   task automatic wrsr(input logic [7:0] v);
      sel(); send(8'h01); send(v); desel();
   endtask

   task automatic mwrite(input logic [15:0] a, input logic [7:0] d);
      sel(); send(8'h02); send(a[15:8]); send(a[7:0]); send(d); desel();
   endtask

   task automatic mread(input logic [15:0] a, output logic [7:0] d);
      sel(); send(8'h03); send(a[15:8]); send(a[7:0]); xfer(8'h00, d); desel();
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      logic [7:0] s;
      chk("R13 so_oe after reset", {7'd0, so_oe}, 8'h00);
      rdsr(s);
      chk("R13 status after reset", s, 8'h00);
   endtask

   task automatic t_wel();
      logic [7:0] s;
      cmd1(8'h06); rdsr(s);
      chk("R3 WREN sets latch", s, 8'h02);
      sel(); send(8'h05);
      begin
         logic [7:0] s1, s2;
         xfer(8'h00, s1); xfer(8'h00, s2);
         chk("R4 status repeats", s2, 8'h02);
      end
      desel();
      cmd1(8'h04); rdsr(s);
      chk("R3 WRDI clears latch", s, 8'h00);
   endtask

   task automatic t_burst();
      logic [7:0] d0, d1, d2, s;
      cmd1(8'h06);
      sel(); send(8'h02); send(8'h01); send(8'h23);
      send(8'hA5); send(8'h3C); send(8'hF0); desel();
      rdsr(s);
      chk("R10 latch cleared after memory write", s, 8'h00);
      sel(); send(8'h03); send(8'h01); send(8'h23);
      xfer(8'h00, d0); xfer(8'h00, d1); xfer(8'h00, d2); desel();
      chk("R7 byte0 stored / R2 order", d0, 8'hA5);
      chk("R6 burst read byte1", d1, 8'h3C);
      chk("R6 burst read byte2", d2, 8'hF0);
      mread(16'hF923, d0);
      chk("R6 upper address bits ignored", d0, 8'hA5);
      mwrite(16'h0123, 8'h00);
      mread(16'h0123, d0);
      chk("R7 write without latch discarded", d0, 8'hA5);
   endtask

   task automatic t_wrap();
      logic [7:0] d0, d1;
      cmd1(8'h06);
      sel(); send(8'h02); send(8'h07); send(8'hFF);
      send(8'h11); send(8'h22); desel();
      sel(); send(8'h03); send(8'h07); send(8'hFF);
      xfer(8'h00, d0); xfer(8'h00, d1); desel();
      chk("R8 byte at top address", d0, 8'h11);
      chk("R8 read wraps to zero", d1, 8'h22);
      mread(16'h0000, d0);
      chk("R8 write wrapped to zero", d0, 8'h22);
   endtask

   task automatic t_protect();
      logic [7:0] d, s;
      cmd1(8'h06); mwrite(16'h0000, 8'h10);
      cmd1(8'h06); mwrite(16'h0400, 8'h40);
      cmd1(8'h06); mwrite(16'h05FF, 8'h5F);
      cmd1(8'h06); mwrite(16'h0600, 8'h60);
      cmd1(8'h06); wrsr(8'h04); rdsr(s);
      chk("R5 status loaded bp=01", s, 8'h04);
      cmd1(8'h06); mwrite(16'h0600, 8'hFF); mread(16'h0600, d);
      chk("R9 quarter protected", d, 8'h60);
      cmd1(8'h06); mwrite(16'h05FF, 8'hAA); mread(16'h05FF, d);
      chk("R9 below quarter writable", d, 8'hAA);
      cmd1(8'h06); wrsr(8'h08);
      cmd1(8'h06); mwrite(16'h0400, 8'hFF); mread(16'h0400, d);
      chk("R9 half protected", d, 8'h40);
      cmd1(8'h06); wrsr(8'h0C);
      cmd1(8'h06); mwrite(16'h0000, 8'hFF); mread(16'h0000, d);
      chk("R9 whole array protected", d, 8'h10);
      rdsr(s);
      chk("R10 latch cleared after discarded write", s, 8'h0C);
      cmd1(8'h06); wrsr(8'h00);
   endtask

   task automatic t_wp();
      logic [7:0] s;
      wp_n = 1'b0;
      cmd1(8'h06); wrsr(8'h8C); rdsr(s);
      chk("R5 pin low blocks status write", s, 8'h00);
      wp_n = 1'b1;
      cmd1(8'h06); wrsr(8'h8C); rdsr(s);
      chk("R5 status write accepted, R10 latch cleared", s, 8'h8C);
      cmd1(8'h06); wrsr(8'h00); rdsr(s);
      chk("R5 status cleared", s, 8'h00);
   endtask

   task automatic t_hold();
      logic [7:0] d0, d1;
      logic r;
      cmd1(8'h06);
      sel(); send(8'h02); send(8'h00); send(8'h20);
      send(8'hC3); send(8'h96); desel();
      sel(); send(8'h03); send(8'h00); send(8'h20);
      for (int i = 7; i >= 4; i--) begin bit_xfer(1'b0, r); d0[i] = r; end
      hold_n = 1'b0;
      wait_n(4 * H);
      chk("R11 output released while held", {7'd0, so_oe}, 8'h00);
      for (int k = 0; k < 3; k++) begin
         sck = 1'b1; wait_n(H); sck = 1'b0; wait_n(H);
      end
      hold_n = 1'b1;
      wait_n(H);
      for (int i = 3; i >= 0; i--) begin bit_xfer(1'b0, r); d0[i] = r; end
      xfer(8'h00, d1);
      desel();
      chk("R11 byte intact across hold", d0, 8'hC3);
      chk("R11 following byte intact", d1, 8'h96);
   endtask

   task automatic t_unknown();
      logic [7:0] s;
      sel(); send(8'hAB); send(8'h06);
      chk("R12 output off after unknown opcode", {7'd0, so_oe}, 8'h00);
      desel();
      rdsr(s);
      chk("R12 later opcode ignored", s, 8'h00);
   endtask

   task automatic t_deselect();
      logic [7:0] s, d;
      cmd1(8'h06);
      for (int i = 0; i < 16; i++) begin
         si = (i % 3 == 0);
         sck = 1'b1; wait_n(H); sck = 1'b0; wait_n(H);
      end
      chk("R1 output off while deselected", {7'd0, so_oe}, 8'h00);
      rdsr(s);
      chk("R1 clocks ignored while deselected", s, 8'h02);
      sel(); send(8'h02); send(8'h00); send(8'h30);
      for (int i = 0; i < 4; i++) begin
         logic r;
         bit_xfer(1'b1, r);
      end
      desel();
      rdsr(s);
      chk("R1 aborted write leaves latch set", s, 8'h02);
      cmd1(8'h06); mwrite(16'h0030, 8'h5A);
      cmd1(8'h06);
      sel(); send(8'h02); send(8'h00); send(8'h30);
      for (int i = 0; i < 5; i++) begin
         logic r;
         bit_xfer(1'b0, r);
      end
      desel();
      mread(16'h0030, d);
      chk("R1 partial byte not stored", d, 8'h5A);
      cmd1(8'h04);
   endtask

   initial begin
      wait_n(5);
      rst_n = 1'b1;
      wait_n(5);
      t_reset();
      t_wel();
      t_burst();
      t_wrap();
      t_protect();
      t_wp();
      t_hold();
      t_unknown();
      t_deselect();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule